// File: doc/BRIEF.md
# Word FIFO Pair with Self-Clearing Flush

This block holds the data path between the register side of a packet-mode serial bus controller and its bus engine. It has one queue per direction, each made of 32-bit entries that carry four bytes. The register side writes words into the outbound queue and reads words from the inbound queue. The bus engine drains the outbound queue and fills the inbound queue. When a transfer ends on a partial word, that word still takes one full entry. Its low bytes carry the data and all 32 bits are stored unaltered.

A configuration register holds two trigger thresholds and two flush bits. A flush bit stays set while its flush is pending and then clears itself, so software polls it until it reads zero. A level register packs two 4-bit counts: the free slots of the outbound queue and the filled slots of the inbound queue. A count clamps at 15 if the depth is larger than that. Two level outputs go to an interrupt block. The outbound request is high while the free count exceeds the outbound trigger. The inbound request is high while the filled count exceeds the inbound trigger.

Top module: `wfp_word_fifo_pair`

## Requirements
- R1: After reset both queues are empty, `cfg_rdata` reads 0, `lvl_rdata` reads 0x80 (8 free, 0 filled), `tx_req` is 1, `rx_req` is 0, `eng_tx_valid` is 0 and `eng_rx_full` is 0.
- R2: Words pushed with `txq_push` reach `eng_tx_data` in push order. `eng_tx_valid` is high exactly while the outbound queue holds a word, and each `eng_tx_pop` advances to the next word.
- R3: A `txq_push` while the outbound queue is full is dropped. `txq_ovf` is high for the one cycle after that clock edge, and the stored words are unchanged.
- R4: Words pushed by the engine with `eng_rx_push` appear on `rxq_rdata` oldest first. Each `rxq_pop` advances to the next word.
- R5: An `rxq_pop` while the inbound queue is empty changes nothing. `rxq_unf` is high for the one cycle after that clock edge.
- R6: `lvl_rdata[7:4]` is the number of free outbound slots and `lvl_rdata[3:0]` is the number of filled inbound slots. Each count is updated in the cycle after the push or pop.
- R7: Writing 1 to `cfg_wdata[1]` sets the outbound flush bit and writing 1 to `cfg_wdata[0]` sets the inbound flush bit. A set bit reads as 1 for one cycle. At the next edge its queue is emptied and the bit reads 0 again. The other queue is not touched.
- R8: While a flush bit is set, the next edge empties that queue whatever push or pop is requested in the same cycle. The dropped request raises no `txq_ovf` or `rxq_unf` pulse.
- R9: The inbound trigger is `cfg_wdata[4:2]` and the outbound trigger is `cfg_wdata[7:5]`. Both are read back at the same bit positions. `tx_req` = free count > outbound trigger, and `rx_req` = filled count > inbound trigger.
- R10: `eng_rx_full` is high while the inbound queue holds 8 words. An `eng_rx_push` at that time is dropped and the stored words are unchanged.
- R11: A partial final word, such as 0x000000AB, takes exactly one entry and is returned with all 32 bits as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_wdata | input | 8 | Configuration write value (flush bits, triggers) |
| cfg_rdata | output | 8 | Configuration read value |
| lvl_rdata | output | 8 | Packed free/filled counts |
| txq_push | input | 1 | Register side pushes a word outbound |
| txq_wdata | input | 32 | Word to push outbound |
| txq_ovf | output | 1 | One-cycle pulse: push to full outbound queue |
| rxq_pop | input | 1 | Register side pops an inbound word |
| rxq_rdata | output | 32 | Oldest inbound word |
| rxq_unf | output | 1 | One-cycle pulse: pop from empty inbound queue |
| eng_tx_valid | output | 1 | Outbound queue holds a word |
| eng_tx_data | output | 32 | Oldest outbound word |
| eng_tx_pop | input | 1 | Engine consumes the oldest outbound word |
| eng_rx_push | input | 1 | Engine delivers an inbound word |
| eng_rx_data | input | 32 | Inbound word from the engine |
| eng_rx_full | output | 1 | Inbound queue is full |
| tx_req | output | 1 | Outbound data request level |
| rx_req | output | 1 | Inbound data request level |

## Verification
The properties assume that every input holds a known value from the first edge after reset. They also assume that only a pending flush bit stops a rejection on a full or empty queue, so an engine pop on an empty outbound queue or an engine push on a full inbound queue is simply dropped. The stimulus drives every input to 0 from time zero and changes inputs only on falling edges. It writes the configuration register only as a single-cycle strobe. Each scenario starts from empty queues, reached by a flush of both queues.

// File: rtl/wfp_pkg.sv
// Package: bit positions of the configuration register and level-field geometry.
// Assumes: flush bits sit at the bottom of the configuration word, triggers above.
package wfp_pkg;
    localparam int FLUSH_RX_BIT = 0;
    localparam int FLUSH_TX_BIT = 1;
    localparam int TRIG_LSB     = 2;
    localparam int NIB_W        = 4;
    localparam int NIB_MAX      = (1 << NIB_W) - 1;

    typedef enum logic {
        REJ_PUSH_FULL = 1'b1,
        REJ_POP_EMPTY = 1'b0
    } rej_kind_e;
endpackage

// File: rtl/wfp_fifo.sv
// Module: synchronous word queue with a flush input and a registered rejection pulse.
// Assumes: DEPTH >= 2. A flush wins over any push or pop in the same cycle.
// The REJ parameter picks which misuse raises the pulse: push-when-full or pop-when-empty.
module wfp_fifo
    import wfp_pkg::*;
#(
    parameter int        DEPTH = 8,
    parameter int        W     = 32,
    parameter rej_kind_e REJ   = REJ_PUSH_FULL,
    localparam int       AW    = $clog2(DEPTH),
    localparam int       CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          rej_pulse
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push_ok;
    logic          pop_ok;
    logic          rej_d;

    // Status flags derived from the occupancy counter.
    always_comb begin
        full  = (count == CW'(DEPTH));
        empty = (count == '0);
    end

    // Qualify requests: a pending flush or a full/empty queue drops them.
    always_comb begin
        push_ok = push && !full && !flush;
        pop_ok  = pop && !empty && !flush;
    end

    // Oldest entry is presented combinationally (show-ahead).
    always_comb head_data = mem[rd_ptr];

    // Select which misuse raises the rejection pulse.
    generate
        if (REJ == REJ_PUSH_FULL) begin : g_rej_push
            always_comb rej_d = push && full && !flush;
        end else begin : g_rej_pop
            always_comb rej_d = pop && empty && !flush;
        end
    endgenerate

    // Storage write; data words carry no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Pointer and counter update with flush priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Rejection pulse register: high for one cycle after the offending edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rej_pulse <= 1'b0;
        else        rej_pulse <= rej_d;
    end
endmodule

// File: rtl/wfp_cfg.sv
// Module: configuration register holding two trigger fields and two self-clearing flush bits.
// Assumes: a flush bit written as 1 is held for exactly one cycle; the queue clears at the
// following edge, when the bit drops unless the same write strobe sets it again.
module wfp_cfg
    import wfp_pkg::*;
#(
    parameter int  TRIG_W = 3,
    localparam int CFG_W  = TRIG_LSB + 2 * TRIG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CFG_W-1:0]  wdata,
    output logic              tx_flush,
    output logic              rx_flush,
    output logic [TRIG_W-1:0] tx_trig,
    output logic [TRIG_W-1:0] rx_trig,
    output logic [CFG_W-1:0]  rdata
);
    // Flush bits: set by a write, cleared on every cycle without a setting write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_flush <= 1'b0;
            rx_flush <= 1'b0;
        end else begin
            tx_flush <= wr && wdata[FLUSH_TX_BIT];
            rx_flush <= wr && wdata[FLUSH_RX_BIT];
        end
    end

    // Trigger fields: loaded on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_trig <= '0;
            rx_trig <= '0;
        end else if (wr) begin
            rx_trig <= wdata[TRIG_LSB +: TRIG_W];
            tx_trig <= wdata[TRIG_LSB + TRIG_W +: TRIG_W];
        end
    end

    // Read-back view at the same bit positions as the write.
    always_comb rdata = {tx_trig, rx_trig, tx_flush, rx_flush};
endmodule

// File: rtl/wfp_level.sv
// Module: converts queue occupancies into the packed level word and the request levels.
// Assumes: counts never exceed DEPTH; fields clamp to the nibble maximum when DEPTH > 15.
module wfp_level
    import wfp_pkg::*;
#(
    parameter int  DEPTH  = 8,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int TRIG_W = $clog2(DEPTH)
) (
    input  logic [CW-1:0]      tx_count,
    input  logic [CW-1:0]      rx_count,
    input  logic [TRIG_W-1:0]  tx_trig,
    input  logic [TRIG_W-1:0]  rx_trig,
    output logic [2*NIB_W-1:0] lvl,
    output logic               tx_req,
    output logic               rx_req
);
    logic [CW-1:0]    tx_free;
    logic [NIB_W-1:0] tx_nib;
    logic [NIB_W-1:0] rx_nib;

    // Free outbound slots.
    always_comb tx_free = CW'(DEPTH) - tx_count;

    // Clamp each count into its nibble only when the depth can overflow it.
    generate
        if (CW > NIB_W) begin : g_clamp
            always_comb begin
                tx_nib = (tx_free  > CW'(NIB_MAX)) ? NIB_W'(NIB_MAX) : tx_free[NIB_W-1:0];
                rx_nib = (rx_count > CW'(NIB_MAX)) ? NIB_W'(NIB_MAX) : rx_count[NIB_W-1:0];
            end
        end else begin : g_plain
            always_comb begin
                tx_nib = NIB_W'(tx_free);
                rx_nib = NIB_W'(rx_count);
            end
        end
    endgenerate

    // Pack the level word: outbound free on top, inbound filled below.
    always_comb lvl = {tx_nib, rx_nib};

    // Threshold comparison for the interrupt block.
    always_comb begin
        tx_req = tx_free  > CW'(tx_trig);
        rx_req = rx_count > CW'(rx_trig);
    end
endmodule

// File: rtl/wfp_word_fifo_pair.sv
// Module: top of the word FIFO pair. Register side pushes outbound / pops inbound words,
// the bus engine pops outbound / pushes inbound words. Holds the configuration register,
// the level word and the two data-request levels.
// Assumes: one clock domain; engine-side misuse is dropped silently.
module wfp_word_fifo_pair
    import wfp_pkg::*;
#(
    parameter int  DEPTH          = 8,
    parameter int  BYTES_PER_WORD = 4,
    localparam int WORD_W         = 8 * BYTES_PER_WORD,
    localparam int TRIG_W         = $clog2(DEPTH),
    localparam int CFG_W          = TRIG_LSB + 2 * TRIG_W,
    localparam int LVL_W          = 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic [LVL_W-1:0]  lvl_rdata,
    input  logic              txq_push,
    input  logic [WORD_W-1:0] txq_wdata,
    output logic              txq_ovf,
    input  logic              rxq_pop,
    output logic [WORD_W-1:0] rxq_rdata,
    output logic              rxq_unf,
    output logic              eng_tx_valid,
    output logic [WORD_W-1:0] eng_tx_data,
    input  logic              eng_tx_pop,
    input  logic              eng_rx_push,
    input  logic [WORD_W-1:0] eng_rx_data,
    output logic              eng_rx_full,
    output logic              tx_req,
    output logic              rx_req
);
    localparam int CW = $clog2(DEPTH + 1);

    logic              tx_flush;
    logic              rx_flush;
    logic [TRIG_W-1:0] tx_trig;
    logic [TRIG_W-1:0] rx_trig;
    logic [CW-1:0]     tx_count;
    logic [CW-1:0]     rx_count;
    logic              tx_full;
    logic              tx_empty;
    logic              rx_full;
    logic              rx_empty;

    wfp_cfg #(.TRIG_W(TRIG_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .wdata    (cfg_wdata),
        .tx_flush (tx_flush),
        .rx_flush (rx_flush),
        .tx_trig  (tx_trig),
        .rx_trig  (rx_trig),
        .rdata    (cfg_rdata)
    );

    wfp_fifo #(.DEPTH(DEPTH), .W(WORD_W), .REJ(REJ_PUSH_FULL)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (txq_push),
        .push_data (txq_wdata),
        .pop       (eng_tx_pop),
        .head_data (eng_tx_data),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty),
        .rej_pulse (txq_ovf)
    );

    wfp_fifo #(.DEPTH(DEPTH), .W(WORD_W), .REJ(REJ_POP_EMPTY)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rxq_pop),
        .head_data (rxq_rdata),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty),
        .rej_pulse (rxq_unf)
    );

    wfp_level #(.DEPTH(DEPTH)) u_lvl (
        .tx_count (tx_count),
        .rx_count (rx_count),
        .tx_trig  (tx_trig),
        .rx_trig  (rx_trig),
        .lvl      (lvl_rdata),
        .tx_req   (tx_req),
        .rx_req   (rx_req)
    );

    // Engine-side handshake flags.
    always_comb begin
        eng_tx_valid = !tx_empty;
        eng_rx_full  = rx_full && !rx_empty;
    end

    // Outbound full flag is consumed only by the rejection logic inside the queue.
    logic unused_tx_full;
    always_comb unused_tx_full = tx_full;
endmodule

// File: rtl/wfp_checker.sv
// Module: protocol checker bound to the top; relates port behaviour across cycles.
// Assumes: inputs are known after reset.
module wfp_checker #(
    parameter int  DEPTH    = 8,
    localparam int TRIG_W   = $clog2(DEPTH),
    localparam int CFG_W    = 2 + 2 * TRIG_W,
    localparam int FULL_NIB = (DEPTH > 15) ? 15 : DEPTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic [7:0]       lvl_rdata,
    input logic             txq_push,
    input logic             txq_ovf,
    input logic             rxq_pop,
    input logic             rxq_unf,
    input logic             eng_tx_valid,
    input logic             eng_rx_full,
    input logic             rx_req
);
    AST_TX_IDLE_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_tx_valid |-> lvl_rdata[7:4] == 4'(FULL_NIB)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (txq_push && lvl_rdata[7:4] == 4'd0 && !cfg_rdata[1]) |=> txq_ovf); // R3
    AST_UNDERFLOW_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (rxq_pop && lvl_rdata[3:0] == 4'd0 && !cfg_rdata[0]) |=> rxq_unf); // R5
    AST_TX_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[1] && !cfg_wr) |=> !cfg_rdata[1]); // R7
    AST_TX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[1] |=> lvl_rdata[7:4] == 4'(FULL_NIB)); // R8
    AST_RX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[0] |=> lvl_rdata[3:0] == 4'd0); // R8
    AST_RX_REQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_rdata[3:0] == 4'd0 |-> !rx_req); // R9
    AST_RX_FULL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rx_full |-> lvl_rdata[3:0] == 4'(FULL_NIB)); // R10
endmodule

bind wfp_word_fifo_pair wfp_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/wfp_word_fifo_pair_test.sv
module wfp_word_fifo_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [7:0]  lvl_rdata;
    logic        txq_push = 1'b0;
    logic [31:0] txq_wdata = '0;
    logic        txq_ovf;
    logic        rxq_pop = 1'b0;
    logic [31:0] rxq_rdata;
    logic        rxq_unf;
    logic        eng_tx_valid;
    logic [31:0] eng_tx_data;
    logic        eng_tx_pop = 1'b0;
    logic        eng_rx_push = 1'b0;
    logic [31:0] eng_rx_data = '0;
    logic        eng_rx_full;
    logic        tx_req;
    logic        rx_req;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    wfp_word_fifo_pair uut (.*);

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int txt, input int rxt, input bit txf, input bit rxf);
        cfg_wr    = 1'b1;
        cfg_wdata = {3'(txt), 3'(rxt), txf, rxf};
        tick();
        cfg_wr    = 1'b0;
    endtask

    task automatic clear_all();
        write_cfg(0, 0, 1, 1);
        tick();
    endtask

    task automatic push_tx(input logic [31:0] d);
        txq_push = 1'b1; txq_wdata = d;
        tick();
        txq_push = 1'b0;
    endtask

    task automatic push_rx(input logic [31:0] d);
        eng_rx_push = 1'b1; eng_rx_data = d;
        tick();
        eng_rx_push = 1'b0;
    endtask

    task automatic pop_tx();
        eng_tx_pop = 1'b1;
        tick();
        eng_tx_pop = 1'b0;
    endtask

    task automatic pop_rx();
        rxq_pop = 1'b1;
        tick();
        rxq_pop = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cfg", 32'(cfg_rdata), 32'h0);
        chk("R1 lvl", 32'(lvl_rdata), 32'h80);
        chk("R1 tx_req", 32'(tx_req), 32'h1);
        chk("R1 rx_req", 32'(rx_req), 32'h0);
        chk("R1 valid", 32'(eng_tx_valid), 32'h0);
        chk("R1 full", 32'(eng_rx_full), 32'h0);
    endtask

    task automatic t_tx_order();
        push_tx(32'hA1A1_0001); push_tx(32'hB2B2_0002); push_tx(32'hC3C3_0003);
        chk("R6 tx free", 32'(lvl_rdata), 32'h50);
        chk("R2 valid", 32'(eng_tx_valid), 32'h1);
        chk("R2 word0", eng_tx_data, 32'hA1A1_0001); pop_tx();
        chk("R2 word1", eng_tx_data, 32'hB2B2_0002); pop_tx();
        chk("R2 word2", eng_tx_data, 32'hC3C3_0003); pop_tx();
        chk("R2 drained", 32'(eng_tx_valid), 32'h0);
    endtask

    task automatic t_tx_overflow();
        for (int i = 0; i < 8; i++) push_tx(32'h1000 + 32'(i));
        chk("R3 full level", 32'(lvl_rdata[7:4]), 32'h0);
        push_tx(32'hDEAD_BEEF);
        chk("R3 ovf pulse", 32'(txq_ovf), 32'h1);
        tick();
        chk("R3 ovf one cycle", 32'(txq_ovf), 32'h0);
        for (int i = 0; i < 8; i++) begin
            chk("R3 contents", eng_tx_data, 32'h1000 + 32'(i));
            pop_tx();
        end
        chk("R3 extra dropped", 32'(eng_tx_valid), 32'h0);
    endtask

    task automatic t_rx_order();
        push_rx(32'h0BAD_0001); push_rx(32'h0BAD_0002); push_rx(32'h0BAD_0003);
        chk("R6 rx avail", 32'(lvl_rdata), 32'h83);
        chk("R4 word0", rxq_rdata, 32'h0BAD_0001); pop_rx();
        chk("R4 word1", rxq_rdata, 32'h0BAD_0002); pop_rx();
        chk("R4 word2", rxq_rdata, 32'h0BAD_0003); pop_rx();
        chk("R4 empty", 32'(lvl_rdata), 32'h80);
    endtask

    task automatic t_rx_underflow();
        pop_rx();
        chk("R5 unf pulse", 32'(rxq_unf), 32'h1);
        chk("R5 level", 32'(lvl_rdata), 32'h80);
        tick();
        chk("R5 unf one cycle", 32'(rxq_unf), 32'h0);
    endtask

    task automatic t_rx_full();
        for (int i = 0; i < 9; i++) push_rx(32'h7700 + 32'(i));
        chk("R10 full flag", 32'(eng_rx_full), 32'h1);
        chk("R10 level", 32'(lvl_rdata[3:0]), 32'h8);
        for (int i = 0; i < 7; i++) pop_rx();
        chk("R10 last kept", rxq_rdata, 32'h7707);
        pop_rx();
        chk("R10 ninth dropped", 32'(lvl_rdata[3:0]), 32'h0);
    endtask

    task automatic t_flush();
        for (int i = 0; i < 4; i++) push_tx(32'(i));
        push_rx(32'h11); push_rx(32'h22);
        write_cfg(0, 0, 1, 0);
        chk("R7 tx bit set", 32'(cfg_rdata), 32'h02);
        chk("R7 tx not yet", 32'(lvl_rdata), 32'h42);
        tick();
        chk("R7 tx bit clear", 32'(cfg_rdata), 32'h00);
        chk("R7 tx emptied rx kept", 32'(lvl_rdata), 32'h82);
        write_cfg(0, 0, 0, 1);
        chk("R7 rx bit set", 32'(cfg_rdata), 32'h01);
        tick();
        chk("R7 rx emptied", 32'(lvl_rdata), 32'h80);
        chk("R7 rx bit clear", 32'(cfg_rdata), 32'h00);
    endtask

    task automatic t_flush_priority();
        for (int i = 0; i < 8; i++) push_tx(32'h5500 + 32'(i));
        write_cfg(0, 0, 1, 1);
        txq_push = 1'b1; txq_wdata = 32'hFEED_0000;
        rxq_pop  = 1'b1;
        tick();
        txq_push = 1'b0; rxq_pop = 1'b0;
        chk("R8 push dropped", 32'(lvl_rdata), 32'h80);
        chk("R8 no ovf", 32'(txq_ovf), 32'h0);
        chk("R8 no unf", 32'(rxq_unf), 32'h0);
    endtask

    task automatic t_triggers();
        write_cfg(5, 1, 0, 0);
        chk("R9 field positions", 32'(cfg_rdata), 32'hA4);
        chk("R9 tx_req 8>5", 32'(tx_req), 32'h1);
        push_tx(32'h1); push_tx(32'h2); push_tx(32'h3);
        chk("R9 tx_req 5>5", 32'(tx_req), 32'h0);
        push_rx(32'h9);
        chk("R9 rx_req 1>1", 32'(rx_req), 32'h0);
        push_rx(32'hA);
        chk("R9 rx_req 2>1", 32'(rx_req), 32'h1);
        clear_all();
    endtask

    task automatic t_partial();
        push_tx(32'h0000_00AB);
        chk("R11 one entry", 32'(lvl_rdata[7:4]), 32'h7);
        chk("R11 word intact", eng_tx_data, 32'h0000_00AB);
        pop_tx();
        push_tx(32'hFFFF_FFFF);
        chk("R11 full word", eng_tx_data, 32'hFFFF_FFFF);
        clear_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        vectors++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_order();
        t_tx_overflow();
        t_rx_order();
        t_rx_underflow();
        t_rx_full();
        t_flush();
        t_flush_priority();
        t_triggers();
        t_partial();
        finish_run();
    end
endmodule